// File: doc/BRIEF.md
# Strobed Score Display Segment Decoder

This block sits between a host CPU's two 8-bit output ports and a strobed seven-segment score display. The host first writes a data byte. Its low nibble is a BCD digit code, bits 6:4 are a centre-segment field that passes through unused, and bit 7 is a DIP-enable flag. The host then writes a strobe byte that names a display group and a digit position inside that group. On each valid strobe the block turns the latched code into a segment pattern and stores it in a 64-entry, 10-bit digit register file. The same write also goes out as a one-cycle index/pattern/valid pulse.

There are two kinds of group. The two player groups drive digits whose middle segments are split. Their 7-segment pattern is widened to 10 bits, and when data bit 7 is low a centred '1' is laid over it. The credit/ball group uses the plain 7-bit pattern. If data bit 7 is low on a credit write, the block rewrites its latched data to 1 and displays a '1'. Later strobes keep that rewritten value until the host writes new data.

Top module: `disp_seg_drv`

## Requirements
- R1: After asynchronous reset (rst_ni low), every digit entry reads 0, wr_valid_o is 0, and the latched data byte is 0.
- R2: Segment map for codes 0..15 (bit 0 = segment a … bit 6 = segment g): 3f, 06, 5b, 4f, 66, 6d, 7c, 07, 7f, 67, 58, 4c, 62, 69, 78, 00. A credit-group write with data bit 7 = 1 stores this 7-bit value zero-extended to 10 bits.
- R3: Strobe bits 6:4 select the group: 001 selects player group A at base 0, 010 selects player group B at base 20, and 100 selects the credit/ball group at base 40. Any other value writes nothing and raises no valid pulse.
- R4: The written entry index is the group base plus strobe bits 3:0.
- R5: For a player group, the 10-bit pattern has bits 5:0 equal to map bits 5:0, bits 7 and 6 both equal to map bit 6, and bits 9:8 zero when data bit 7 = 1.
- R6: For a player group with data bit 7 = 0, pattern bits 9:8 are forced to 1. The other bits follow R5.
- R7: For the credit group with data bit 7 = 0, the stored pattern is 0x006 (code 1), and the latched data becomes 0x01. A later strobe with no data write therefore uses 0x01.
- R8: The data byte is latched on data_we_i and held until the next data write. A strobe uses the value latched before its own cycle, so a data write in the same cycle is not seen by that strobe.
- R9: The entry and the wr_* outputs update on the clock edge that samples strobe_we_i. wr_valid_o is high for exactly one cycle per valid strobe. Entries that are not addressed keep their values.
- R10: Strobe bit 7 and data bits 6:4 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_we_i | input | 1 | Data byte write strobe |
| data_i | input | 8 | Data byte: BCD code, centre field, DIP-enable |
| strobe_we_i | input | 1 | Strobe byte write strobe |
| strobe_i | input | 8 | Strobe byte: digit position (3:0), group (6:4) |
| rd_idx_i | input | 6 | Display read index |
| rd_pat_o | output | 10 | Pattern stored at rd_idx_i |
| wr_valid_o | output | 1 | One-cycle pulse when an entry is written |
| wr_index_o | output | 6 | Index of the written entry |
| wr_pattern_o | output | 10 | Pattern written |

## Verification
The assertions assume that the host's write strobes are clean single-cycle pulses, synchronous to clk_i. They also assume that strobe bits 3:0 stay below 16, so each group's entries stay inside its own window. The stimulus drives both write strobes on the falling edge and holds each one for exactly one cycle. It also uses only codes and positions that keep the indices inside 0..15, 20..35 and 40..55. Invalid group codes are sent on purpose to confirm that they produce neither a pulse nor a register change.

// File: rtl/disp_seg_pkg.sv
package disp_seg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEG8_W = 8;
  localparam int unsigned PAT_W  = 10;

  typedef enum logic [1:0] {
    GRP_PA   = 2'd0,
    GRP_PB   = 2'd1,
    GRP_CRD  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  function automatic grp_e grp_decode(input logic [2:0] sel);
    case (sel)
      3'b001:  return GRP_PA;
      3'b010:  return GRP_PB;
      3'b100:  return GRP_CRD;
      default: return GRP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/disp_bcd_seg.sv
module disp_bcd_seg
  import disp_seg_pkg::*;
(
  input  logic [3:0]        code_i,
  output logic [SEG8_W-1:0] seg_o
);
  // bit0 = a ... bit6 = g; codes 10..15 are display glyphs, not hex
  always_comb begin
    case (code_i)
      4'd0:    seg_o = 8'h3f;
      4'd1:    seg_o = 8'h06;
      4'd2:    seg_o = 8'h5b;
      4'd3:    seg_o = 8'h4f;
      4'd4:    seg_o = 8'h66;
      4'd5:    seg_o = 8'h6d;
      4'd6:    seg_o = 8'h7c;
      4'd7:    seg_o = 8'h07;
      4'd8:    seg_o = 8'h7f;
      4'd9:    seg_o = 8'h67;
      4'd10:   seg_o = 8'h58;
      4'd11:   seg_o = 8'h4c;
      4'd12:   seg_o = 8'h62;
      4'd13:   seg_o = 8'h69;
      4'd14:   seg_o = 8'h78;
      default: seg_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/disp_seg_widen.sv
module disp_seg_widen
  import disp_seg_pkg::*;
(
  input  logic [SEG8_W-1:0] seg_i,
  input  logic              mid_one_i,
  output logic [PAT_W-1:0]  pat_o
);
  // split-middle digits: g drives two halves, raw bit7 drives the centre pair
  always_comb begin
    pat_o[5:0] = seg_i[5:0];
    pat_o[6]   = seg_i[6];
    pat_o[7]   = seg_i[6];
    pat_o[8]   = seg_i[7] | mid_one_i;
    pat_o[9]   = seg_i[7] | mid_one_i;
  end
endmodule

// File: rtl/disp_digit_rf.sv
module disp_digit_rf #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 10,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];

  p_wr_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (raddr_i == waddr_i) |=> ($past(raddr_i) != raddr_i) || (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/disp_seg_drv.sv
module disp_seg_drv
  import disp_seg_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 64,
  parameter int unsigned GRP_STRIDE = 20,
  parameter int unsigned GRP_SPAN   = 16,
  localparam int unsigned IDX_W     = $clog2(NUM_DIGITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              strobe_we_i,
  input  logic [BYTE_W-1:0] strobe_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PAT_W-1:0]  rd_pat_o,
  output logic              wr_valid_o,
  output logic [IDX_W-1:0]  wr_index_o,
  output logic [PAT_W-1:0]  wr_pattern_o
);
  localparam logic [IDX_W-1:0] BASE_PA  = IDX_W'(0);
  localparam logic [IDX_W-1:0] BASE_PB  = IDX_W'(GRP_STRIDE);
  localparam logic [IDX_W-1:0] BASE_CRD = IDX_W'(2 * GRP_STRIDE);

  logic [BYTE_W-1:0] data_q;
  grp_e              grp;
  logic              is_player, crd_force;
  logic [3:0]        code;
  logic [SEG8_W-1:0] seg8;
  logic [PAT_W-1:0]  wide, pat;
  logic [IDX_W-1:0]  base, idx;
  logic              hit;
  logic              wr_valid_q;
  logic [IDX_W-1:0]  wr_index_q;
  logic [PAT_W-1:0]  wr_pattern_q;
  logic              unused_strobe_msb;

  assign unused_strobe_msb = strobe_i[7];

  assign grp       = grp_decode(strobe_i[6:4]);
  assign is_player = (grp == GRP_PA) || (grp == GRP_PB);
  assign hit       = strobe_we_i && (grp != GRP_NONE);
  assign crd_force = (grp == GRP_CRD) && !data_q[7];

  // credit writes with DIP-enable low show '1' and persist that in the latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      data_q <= '0;
    else if (data_we_i)               data_q <= data_i;
    else if (strobe_we_i && crd_force) data_q <= BYTE_W'(1);
  end

  assign code = crd_force ? 4'd1 : data_q[3:0];

  disp_bcd_seg u_lut (
    .code_i (code),
    .seg_o  (seg8)
  );

  disp_seg_widen u_widen (
    .seg_i     (seg8),
    .mid_one_i (!data_q[7]),
    .pat_o     (wide)
  );

  always_comb begin
    case (grp)
      GRP_PA:  base = BASE_PA;
      GRP_PB:  base = BASE_PB;
      default: base = BASE_CRD;
    endcase
  end

  assign idx = base + IDX_W'(strobe_i[3:0]);
  assign pat = is_player ? wide : PAT_W'(seg8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_q   <= 1'b0;
      wr_index_q   <= '0;
      wr_pattern_q <= '0;
    end else begin
      wr_valid_q <= hit;
      if (hit) begin
        wr_index_q   <= idx;
        wr_pattern_q <= pat;
      end
    end
  end

  disp_digit_rf #(.DEPTH(NUM_DIGITS), .W(PAT_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hit),
    .waddr_i (idx),
    .wdata_i (pat),
    .raddr_i (rd_idx_i),
    .rdata_o (rd_pat_o)
  );

  assign wr_valid_o   = wr_valid_q;
  assign wr_index_o   = wr_index_q;
  assign wr_pattern_o = wr_pattern_q;

  p_valid_from_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(strobe_we_i));

  p_index_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (int'(wr_index_o) < int'(GRP_SPAN)) ||
                   ((int'(wr_index_o) >= int'(GRP_STRIDE)) && (int'(wr_index_o) < int'(GRP_STRIDE + GRP_SPAN))) ||
                   ((int'(wr_index_o) >= int'(2 * GRP_STRIDE)) && (int'(wr_index_o) < int'(2 * GRP_STRIDE + GRP_SPAN))));

  p_player_g_dup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && (int'(wr_index_o) < int'(2 * GRP_STRIDE)) |-> wr_pattern_o[7] == wr_pattern_o[6]);

  p_credit_narrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && (int'(wr_index_o) >= int'(2 * GRP_STRIDE)) |-> wr_pattern_o[9:7] == 3'b000);

  p_credit_rewrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_we_i && !data_we_i && (strobe_i[6:4] == 3'b100) && !data_q[7]
      |=> (data_q == BYTE_W'(1)) && (wr_pattern_o == PAT_W'(10'h006)));

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we_i && !strobe_we_i |=> $stable(data_q));
endmodule

// File: tb/sim_disp_seg_drv.sv
module sim_disp_seg_drv;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_we_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       strobe_we_i = 1'b0;
  logic [7:0] strobe_i = '0;
  logic [5:0] rd_idx_i = '0;
  logic [9:0] rd_pat_o;
  logic       wr_valid_o;
  logic [5:0] wr_index_o;
  logic [9:0] wr_pattern_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  disp_seg_drv u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .data_we_i(data_we_i), .data_i(data_i),
    .strobe_we_i(strobe_we_i), .strobe_i(strobe_i),
    .rd_idx_i(rd_idx_i), .rd_pat_o(rd_pat_o),
    .wr_valid_o(wr_valid_o), .wr_index_o(wr_index_o), .wr_pattern_o(wr_pattern_o)
  );

  // {data, strobe, index, pattern}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {8'h80, 8'h10, 6'd0,  10'h03f},  // R5 code 0
    {8'h88, 8'h13, 6'd3,  10'h0ff},  // R5 g duplicated
    {8'h02, 8'h25, 6'd25, 10'h3db},  // R6 centre one
    {8'h8f, 8'h2f, 6'd35, 10'h000},  // R4 last in group B
    {8'h8a, 8'h41, 6'd41, 10'h058},  // R2 credit glyph
    {8'h9c, 8'h4f, 6'd55, 10'h062},  // R10 centre field ignored
    {8'h87, 8'h97, 6'd7,  10'h007},  // R10 strobe msb ignored
    {8'h0f, 8'h1a, 6'd10, 10'h300},  // R6 blank plus centre one
    {8'h84, 8'h20, 6'd20, 10'h0e6}   // R4 group B base
  };

  function automatic logic [9:0] ref_map(input int c);
    case (c)
      0: return 10'h3f;  1: return 10'h06;  2: return 10'h5b;  3: return 10'h4f;
      4: return 10'h66;  5: return 10'h6d;  6: return 10'h7c;  7: return 10'h07;
      8: return 10'h7f;  9: return 10'h67; 10: return 10'h58; 11: return 10'h4c;
      12: return 10'h62; 13: return 10'h69; 14: return 10'h78; default: return 10'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_data(input logic [7:0] d);
    @(negedge clk); data_we_i = 1'b1; data_i = d;
    @(negedge clk); data_we_i = 1'b0;
  endtask

  task automatic wr_strobe(input logic [7:0] s);
    @(negedge clk); strobe_we_i = 1'b1; strobe_i = s;
    @(negedge clk); strobe_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] i, output logic [9:0] p);
    rd_idx_i = i; #1; p = rd_pat_o;
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [9:0] p;
    logic       bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 16'(wr_valid_o), 16'h0);
    bad = 1'b0;
    for (int i = 0; i < 64; i++) begin rd(6'(i), p); if (p !== 10'h0) bad = 1'b1; end
    check("R1 entries", 16'(bad), 16'h0);
    rst_ni = 1'b1;

    // table walk: R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      wr_data(VEC[v][31:24]);
      wr_strobe(VEC[v][23:16]);
      check("R9 valid", 16'(wr_valid_o), 16'h1);
      check("R4 index", 16'(wr_index_o), 16'(VEC[v][15:10]));
      check("R5/R6 pattern", 16'(wr_pattern_o), 16'(VEC[v][9:0]));
      rd(VEC[v][15:10], p);
      check("R9 stored", 16'(p), 16'(VEC[v][9:0]));
      @(negedge clk);
      check("R9 one pulse", 16'(wr_valid_o), 16'h0);
    end

    // R9 unaddressed entry unchanged
    rd(6'd2, p);
    check("R9 untouched", 16'(p), 16'h0);

    // R2 full credit map
    for (int c = 0; c < 16; c++) begin
      wr_data(8'h80 | 8'(c));
      wr_strobe(8'h40 | 8'(c));
      check("R2 index", 16'(wr_index_o), 16'(40 + c));
      check("R2 map", 16'(wr_pattern_o), 16'(ref_map(c)));
    end

    // R3 invalid group codes write nothing
    wr_data(8'h85);
    foreach (VEC[k]) begin end
    for (int g = 0; g < 8; g++) begin
      if (g == 1 || g == 2 || g == 4) continue;
      wr_strobe(8'(g << 4) | 8'h03);
      check("R3 no pulse", 16'(wr_valid_o), 16'h0);
    end
    rd(6'd3, p);
    check("R3 entry 3 kept", 16'(p), 16'h0ff);
    rd(6'd23, p);
    check("R3 entry 23 kept", 16'(p), 16'h0);

    // R7 credit rewrite and its persistence
    wr_data(8'h05);
    wr_strobe(8'h42);
    check("R7 credit one", 16'(wr_pattern_o), 16'h006);
    wr_strobe(8'h11);
    check("R7 latch now 01", 16'(wr_pattern_o), 16'h306);

    // R8 same-cycle data write not seen by strobe
    wr_data(8'h81);
    @(negedge clk);
    data_we_i = 1'b1; data_i = 8'h88; strobe_we_i = 1'b1; strobe_i = 8'h1e;
    @(negedge clk);
    data_we_i = 1'b0; strobe_we_i = 1'b0;
    check("R8 old data used", 16'(wr_pattern_o), 16'h006);
    repeat (3) @(negedge clk);
    wr_strobe(8'h1f);
    check("R8 new data held", 16'(wr_pattern_o), 16'h0ff);
    check("R4 index 15", 16'(wr_index_o), 16'd15);

    // R1 asynchronous reset clears entries
    #3 rst_ni = 1'b0; #2;
    rd(6'd15, p);
    check("R1 reset clears", 16'(p), 16'h0);
    @(negedge clk); rst_ni = 1'b1;
    wr_strobe(8'h10);
    check("R1 data cleared", 16'(wr_pattern_o), 16'h33f);

    report();
  end
endmodule